// File: doc/BRIEF.md
# Dual-Issue Slot Reservation Checker

This block sits after decode in an in-order pipeline that can issue two instructions per cycle. Each cycle it receives the class code of the older and the younger candidate and decides which of them may issue. Four shared issue resources (named A, B, C and X here, X being the arithmetic slot) model the pairing limits. Each class claims one of at most two alternative resource sets, tried in a fixed order, and every resource in a set must be free in that cycle.

Some classes also hold resources in later cycles. Long multiplies and multi-register memory operations hold their set for a second cycle. Dividers hold A+X in their first cycle and again in their last, and leave the cycles in between free. A shift-register occupancy map records these pending claims. A new claim that overlaps a pending one, now or later, blocks issue.

The older instruction is placed first. When it cannot be placed, the stall output is raised and neither instruction issues. The younger instruction only gets the resources the older one leaves. It never pairs when the dependency flag is set, and it never pairs when a move is followed by a plain arithmetic operation.

Top module: `dual_issue_checker`

## Requirements
- R1: Class codes are 0 plain arithmetic, 1 arithmetic with register-specified shift, 2 move, 3 single-cycle multiply, 4 two-cycle multiply, 5 unsigned divide, 6 signed divide, 7 one/two-register load/store, 8 three/four-register load/store, 9 branch. Their first-choice and second-choice sets are: 0 A+X then B+X; 1 A+X then B+C+X; 2 A then B+X; 3 and 4 and 5 and 6 A+X only; 7 A+C only; 8 A+B only; 9 B only.
- R2: Synchronous active-low reset clears every pending reservation. With neither input valid, issue_old, issue_yng and stall are all 0.
- R3: The older instruction issues when its first-choice set is free in the current cycle and in every later cycle it needs, or failing that when its second-choice set is. This check uses the pending reservations only.
- R4: stall is 1 exactly when old_valid is 1 and the older instruction does not issue. issue_yng is never 1 unless issue_old is 1.
- R5: The younger instruction is checked the same way as the older one, against the pending reservations plus everything the older instruction claims in this cycle and in later cycles.
- R6: When yng_dep is 1, issue_yng is 0.
- R7: An older move (code 2) never pairs with a younger plain arithmetic operation (code 0).
- R8: Codes 4 and 8 also claim their set in the next cycle, so a following instruction that needs any of those resources stalls for one cycle.
- R9: Code 5 claims A+X again 8 cycles after issue and code 6 claims it 9 cycles after issue. The cycles in between are free. A divider whose later claim would land on a pending one does not issue.
- R10: Codes 10 to 15 claim no resources and always issue when their turn allows.
- R11: When yng_valid is 0, issue_yng is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| old_valid | input | 1 | Older candidate present |
| old_cls | input | 4 | Older class code |
| yng_valid | input | 1 | Younger candidate present |
| yng_cls | input | 4 | Younger class code |
| yng_dep | input | 1 | Younger reads a result of the older |
| issue_old | output | 1 | Older issues this cycle |
| issue_yng | output | 1 | Younger issues this cycle |
| stall | output | 1 | Older candidate is held |

## Verification
A wrong bit in the occupancy map does not show at once. It shows as a spurious or missing stall only in the cycle when that slot reaches the head of the map, which can be up to nine cycles after the instruction that caused it. The divider sequences therefore probe each cycle of the window, including the tail cycle itself. A fault in the placement order shows at once, as a wrong pairing decision in the same cycle as the inputs.

// File: rtl/dis_pkg.sv
// Shared types for the dual-issue slot checker.
// Assumes four issue resources and class codes held in 4 bits.
package dis_pkg;
    localparam int NRES = 4;
    localparam int CLSW = 4;
    localparam int OFFW = 4;

    // Resource bits inside a claim mask
    localparam logic [NRES-1:0] RES_A = 4'b0001;
    localparam logic [NRES-1:0] RES_B = 4'b0010;
    localparam logic [NRES-1:0] RES_C = 4'b0100;
    localparam logic [NRES-1:0] RES_X = 4'b1000;

    typedef enum logic [CLSW-1:0] {
        CLS_ARITH   = 4'd0,
        CLS_SHREG   = 4'd1,
        CLS_MOVE    = 4'd2,
        CLS_MUL1    = 4'd3,
        CLS_MUL2    = 4'd4,
        CLS_UDIV    = 4'd5,
        CLS_SDIV    = 4'd6,
        CLS_MEM1    = 4'd7,
        CLS_MEM2    = 4'd8,
        CLS_BRANCH  = 4'd9
    } cls_e;

    // Resource profile of one class
    typedef struct packed {
        logic [NRES-1:0] pri;      // first-choice set
        logic [NRES-1:0] alt;      // second-choice set
        logic            has_alt;  // second choice exists
        logic [OFFW-1:0] tail;     // later cycle reusing the chosen set, 0 = none
    } prof_t;
endpackage

// File: rtl/dis_class_decode.sv
// Maps a class code to its resource profile.
// Assumes codes outside the defined classes need no resources.
module dis_class_decode
    import dis_pkg::*;
(
    input  logic [CLSW-1:0] cls,
    output prof_t           prof
);
    // Table of alternatives per class
    always_comb begin
        prof = '0;
        case (cls_e'(cls))
            CLS_ARITH:  prof = '{pri: RES_A | RES_X, alt: RES_B | RES_X,         has_alt: 1'b1, tail: 4'd0};
            CLS_SHREG:  prof = '{pri: RES_A | RES_X, alt: RES_B | RES_C | RES_X, has_alt: 1'b1, tail: 4'd0};
            CLS_MOVE:   prof = '{pri: RES_A,         alt: RES_B | RES_X,         has_alt: 1'b1, tail: 4'd0};
            CLS_MUL1:   prof = '{pri: RES_A | RES_X, alt: '0, has_alt: 1'b0, tail: 4'd0};
            CLS_MUL2:   prof = '{pri: RES_A | RES_X, alt: '0, has_alt: 1'b0, tail: 4'd1};
            CLS_UDIV:   prof = '{pri: RES_A | RES_X, alt: '0, has_alt: 1'b0, tail: 4'd8};
            CLS_SDIV:   prof = '{pri: RES_A | RES_X, alt: '0, has_alt: 1'b0, tail: 4'd9};
            CLS_MEM1:   prof = '{pri: RES_A | RES_C, alt: '0, has_alt: 1'b0, tail: 4'd0};
            CLS_MEM2:   prof = '{pri: RES_A | RES_B, alt: '0, has_alt: 1'b0, tail: 4'd1};
            CLS_BRANCH: prof = '{pri: RES_B,         alt: '0, has_alt: 1'b0, tail: 4'd0};
            default:    prof = '0;
        endcase
    end
endmodule

// File: rtl/dis_slot_alloc.sv
// Picks the first alternative of a profile whose resources are free now
// and in its tail cycle. Assumes DEPTH covers the largest tail offset.
module dis_slot_alloc
    import dis_pkg::*;
#(
    parameter int DEPTH = 10
)(
    input  logic                       req,
    input  prof_t                      prof,
    input  logic [DEPTH-1:0][NRES-1:0] busy,
    output logic                       fit,
    output logic [NRES-1:0]            mask
);
    logic [1:0][NRES-1:0] cand;
    logic [1:0]           ok;

    assign cand[0] = prof.pri;
    assign cand[1] = prof.alt;

    for (genvar j = 0; j < 2; j++) begin : g_cand
        logic clash;
        // Collision test of one alternative against the busy map
        always_comb begin
            clash = |(cand[j] & busy[0]);
            for (int d = 1; d < DEPTH; d++) begin
                if (prof.tail == OFFW'(d))
                    clash = clash | (|(cand[j] & busy[d]));
            end
        end
        if (j == 0) begin : g_first
            assign ok[j] = !clash;
        end else begin : g_second
            assign ok[j] = !clash && prof.has_alt;
        end
    end

    assign fit  = req && (|ok);
    assign mask = ok[0] ? cand[0] : cand[1];
endmodule

// File: rtl/dis_occ_map.sv
// Shift-register map of resources reserved for future cycles.
// Entry k holds what is taken k cycles from now; new claims enter by offset.
module dis_occ_map
    import dis_pkg::*;
#(
    parameter int DEPTH = 10
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DEPTH-1:0][NRES-1:0] claim,
    output logic [DEPTH-1:0][NRES-1:0] busy
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        // Advance one slot per cycle, merging claims for the next cycle
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy[k] <= '0;
            else if (k < DEPTH-1)
                busy[k] <= busy[(k < DEPTH-1) ? k+1 : k] | claim[(k < DEPTH-1) ? k+1 : k];
            else
                busy[k] <= '0;
        end
    end
endmodule

// File: rtl/dual_issue_checker.sv
// Decides per cycle whether the older and younger decoded instructions
// issue, using four shared issue resources and a future-occupancy map.
// Assumes DEPTH >= 10 so the signed divider tail fits in the map.
module dual_issue_checker
    import dis_pkg::*;
#(
    parameter int DEPTH = 10
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            old_valid,
    input  logic [CLSW-1:0] old_cls,
    input  logic            yng_valid,
    input  logic [CLSW-1:0] yng_cls,
    input  logic            yng_dep,
    output logic            issue_old,
    output logic            issue_yng,
    output logic            stall
);
    prof_t                      prof_o, prof_y;
    logic [DEPTH-1:0][NRES-1:0] map_q, busy_y, claim_o, claim_y, claim_all;
    logic [NRES-1:0]            mask_o, mask_y;
    logic                       fit_o, fit_y, pair_ok, move_arith;

    dis_class_decode u_dec_o (.cls(old_cls), .prof(prof_o));
    dis_class_decode u_dec_y (.cls(yng_cls), .prof(prof_y));

    dis_slot_alloc #(.DEPTH(DEPTH)) u_alloc_o (
        .req(old_valid), .prof(prof_o), .busy(map_q), .fit(fit_o), .mask(mask_o));

    // Claims of each issued instruction, by cycle offset
    for (genvar d = 0; d < DEPTH; d++) begin : g_claim
        if (d == 0) begin : g_now
            assign claim_o[d] = fit_o ? mask_o : '0;
            assign claim_y[d] = fit_y ? mask_y : '0;
        end else begin : g_later
            assign claim_o[d] = (fit_o && prof_o.tail == OFFW'(d)) ? mask_o : '0;
            assign claim_y[d] = (fit_y && prof_y.tail == OFFW'(d)) ? mask_y : '0;
        end
        assign busy_y[d]    = map_q[d] | claim_o[d];
        assign claim_all[d] = claim_o[d] | claim_y[d];
    end

    assign move_arith = (old_cls == CLS_MOVE) && (yng_cls == CLS_ARITH);
    assign pair_ok    = fit_o && yng_valid && !yng_dep && !move_arith;

    dis_slot_alloc #(.DEPTH(DEPTH)) u_alloc_y (
        .req(pair_ok), .prof(prof_y), .busy(busy_y), .fit(fit_y), .mask(mask_y));

    dis_occ_map #(.DEPTH(DEPTH)) u_map (
        .clk(clk), .rst_n(rst_n), .claim(claim_all), .busy(map_q));

    assign issue_old = fit_o;
    assign issue_yng = fit_y;
    assign stall     = old_valid && !fit_o;
endmodule

// File: rtl/dis_checker.sv
// Property checker for dual_issue_checker, attached by bind.
module dis_checker
    import dis_pkg::*;
#(
    parameter int DEPTH = 10
)(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       yng_dep,
    input logic                       yng_valid,
    input logic                       issue_old,
    input logic                       issue_yng,
    input logic                       stall,
    input logic [DEPTH-1:0][NRES-1:0] map_q,
    input logic [DEPTH-1:0][NRES-1:0] claim_o,
    input logic [DEPTH-1:0][NRES-1:0] claim_y
);
    // R4
    young_needs_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_yng |-> issue_old);
    // R4
    stall_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (claim_o == '0) && !issue_yng);
    // R6
    dep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yng_dep |-> !issue_yng);
    // R11
    yng_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !yng_valid |-> !issue_yng);
    // R5
    disjoint_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_yng |-> ((claim_o[0] & claim_y[0]) == '0));
    // R3
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_old |-> ((claim_o[0] & map_q[0]) == '0));
    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (map_q == '0));
endmodule

bind dual_issue_checker dis_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .yng_dep(yng_dep), .yng_valid(yng_valid),
    .issue_old(issue_old), .issue_yng(issue_yng), .stall(stall),
    .map_q(map_q), .claim_o(claim_o), .claim_y(claim_y));

// File: tb/tb_dual_issue_checker.sv
// Scoreboard bench: the driver predicts from the requirements, the monitor compares.
module tb_dual_issue_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       old_valid = 1'b0, yng_valid = 1'b0, yng_dep = 1'b0;
    logic [3:0] old_cls = '0, yng_cls = '0;
    logic       issue_old, issue_yng, stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit [2:0] q_exp[$];
    string    q_tag[$];
    bit [3:0] mm[10];

    always #5 clk = ~clk;

    dual_issue_checker dut (
        .clk(clk), .rst_n(rst_n), .old_valid(old_valid), .old_cls(old_cls),
        .yng_valid(yng_valid), .yng_cls(yng_cls), .yng_dep(yng_dep),
        .issue_old(issue_old), .issue_yng(issue_yng), .stall(stall));

    // Class profiles (R1); bits: A=1, B=2, C=4, X=8
    function automatic void cls_prof(input int c, output bit [3:0] m0,
                                     output bit [3:0] m1, output bit h1, output int tl);
        m0 = 0; m1 = 0; h1 = 0; tl = 0;
        case (c)
            0: begin m0 = 4'd9;  m1 = 4'd10; h1 = 1; end
            1: begin m0 = 4'd9;  m1 = 4'd14; h1 = 1; end
            2: begin m0 = 4'd1;  m1 = 4'd10; h1 = 1; end
            3: m0 = 4'd9;
            4: begin m0 = 4'd9; tl = 1; end
            5: begin m0 = 4'd9; tl = 8; end
            6: begin m0 = 4'd9; tl = 9; end
            7: m0 = 4'd5;
            8: begin m0 = 4'd3; tl = 1; end
            9: m0 = 4'd2;
            default: ;
        endcase
    endfunction

    function automatic bit fits(input bit [3:0] m, input bit [3:0] now, input bit [3:0] later);
        return ((m & now) == 0) && ((m & later) == 0);
    endfunction

    task automatic drive(input bit ov, input int oc, input bit yv, input int yc,
                         input bit dp, input string tag);
        bit [3:0] m0, m1, om, ym, ob[10], cl[10];
        bit h1, eo, ey;
        int tl, otl;
        @(posedge clk); #1;
        old_valid = ov; old_cls = 4'(oc); yng_valid = yv; yng_cls = 4'(yc); yng_dep = dp;
        eo = 0; ey = 0; om = 0; ym = 0;
        for (int k = 0; k < 10; k++) cl[k] = 0;
        cls_prof(oc, m0, m1, h1, tl);
        otl = tl;
        if (ov) begin
            if (fits(m0, mm[0], tl != 0 ? mm[tl] : 4'd0)) begin eo = 1; om = m0; end
            else if (h1 && fits(m1, mm[0], tl != 0 ? mm[tl] : 4'd0)) begin eo = 1; om = m1; end
        end
        for (int k = 0; k < 10; k++) ob[k] = mm[k];
        if (eo) begin
            ob[0] |= om;
            if (otl != 0) begin ob[otl] |= om; cl[otl] |= om; end
        end
        if (eo && yv && !dp && !(oc == 2 && yc == 0)) begin
            cls_prof(yc, m0, m1, h1, tl);
            if (fits(m0, ob[0], tl != 0 ? ob[tl] : 4'd0)) begin ey = 1; ym = m0; end
            else if (h1 && fits(m1, ob[0], tl != 0 ? ob[tl] : 4'd0)) begin ey = 1; ym = m1; end
            if (ey && tl != 0) cl[tl] |= ym;
        end
        for (int k = 0; k < 9; k++) mm[k] = mm[k+1] | cl[k+1];
        mm[9] = 0;
        q_exp.push_back({eo, ey, ov && !eo});
        q_tag.push_back(tag);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; old_valid = 0; yng_valid = 0; yng_dep = 0;
        for (int k = 0; k < 10; k++) mm[k] = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    // Monitor: compare outputs against predictions between edges
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            bit [2:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({issue_old, issue_yng, stall} !== e) begin
                fails++;
                $display("FAIL %s: {issue_old,issue_yng,stall} actual %b expected %b",
                         t, {issue_old, issue_yng, stall}, e);
            end
        end
    end

    initial begin
        for (int k = 0; k < 10; k++) mm[k] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        drive(0, 0, 0, 0, 0, "R2 idle after reset");
        drive(1, 0, 1, 9, 0, "R5 arith+branch pair");
        drive(1, 0, 1, 0, 0, "R5 arith+arith no pair");
        drive(1, 7, 1, 0, 0, "R5 mem1+arith pair");
        drive(1, 2, 1, 0, 0, "R7 move+arith blocked");
        drive(1, 2, 1, 9, 0, "R5 move+branch pair");
        drive(1, 9, 1, 2, 0, "R3 branch+move pair");
        drive(1, 9, 1, 1, 0, "R1 branch+shreg pair");
        drive(1, 1, 1, 9, 0, "R1 shreg+branch pair");
        drive(1, 3, 1, 7, 0, "R5 mul1+mem1 no pair");
        drive(1, 7, 1, 0, 1, "R6 dependency blocks");
        drive(1, 7, 0, 0, 0, "R11 younger absent");
        drive(1, 12, 1, 13, 0, "R10 spare codes pair");
        drive(1, 12, 1, 0, 0, "R10 spare+arith pair");
        drive(1, 4, 0, 0, 0, "R8 mul2 issue");
        drive(1, 0, 1, 9, 0, "R8 arith stalls behind mul2");
        drive(1, 0, 1, 9, 0, "R8 arith after mul2");
        drive(1, 8, 0, 0, 0, "R8 mem2 issue");
        drive(1, 9, 0, 0, 0, "R8 branch stalls behind mem2");
        drive(1, 9, 0, 0, 0, "R8 branch after mem2");
        drive(1, 5, 0, 0, 0, "R9 udiv issue");
        for (int i = 0; i < 7; i++) drive(1, 0, 0, 0, 0, "R9 udiv free window");
        drive(1, 0, 0, 0, 0, "R9 udiv tail stalls");
        drive(1, 0, 0, 0, 0, "R9 after udiv tail");
        drive(1, 6, 0, 0, 0, "R9 sdiv issue");
        drive(1, 5, 0, 0, 0, "R9 udiv tail collides");
        drive(1, 5, 0, 0, 0, "R9 udiv later issues");
        for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, 0, "R2 drain");
        drive(1, 9, 1, 6, 0, "R5 branch+sdiv pair");
        for (int i = 0; i < 8; i++) drive(1, 9, 0, 0, 0, "R9 sdiv window");
        drive(1, 1, 1, 9, 0, "R9 sdiv tail stalls");
        drive(1, 1, 1, 9, 0, "R9 after sdiv tail");
        drive(1, 6, 0, 0, 0, "R2 sdiv before reset");
        do_reset();
        for (int i = 0; i < 11; i++) drive(1, 0, 1, 9, 0, "R2 reset cleared map");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule